// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Multiplier

This block multiplies two 14-bit floating-point operands in a narrow format for media datapaths. Each word holds a sign, a 5-bit biased exponent (bias 15) and an 8-bit fraction with an implicit leading one. The exponent adder runs beside a 9x9 significand multiplier. A normalizer then shifts the product when it reaches two. The fraction is truncated to 8 bits, and a result whose exponent falls below zero is flushed to a signed zero with an underflow flag.

Subnormals are not supported. Exponent code 0 is an ordinary normal exponent worth 2^-15. Code 31 is never produced by legal use. Overflow, infinity and NaN are not detected. The operands are assumed to stay in a range where they cannot arise. A parameter selects one output register stage, which is the default, or a purely combinational path.

Top module: `fpm_mul14`

## Requirements
- R1: Operand and result words are laid out as bit 13 sign, bits 12:8 biased exponent (bias 15), bits 7:0 fraction, with value (-1)^s * 2^(e-15) * 1.f.
- R2: The result sign is the XOR of the two operand signs, including for zero and flushed results.
- R3: The result exponent is ea + eb - 15 before normalization, and exponent code 0 is accepted and produced as a normal value of scale 2^-15.
- R4: When the 9x9 significand product is at least 2, it is shifted right by one and the result exponent is incremented; this can lift a result from -1 to exponent code 0.
- R5: Rounding is truncation: product bits below the 8 kept fraction bits are discarded and never round the result up.
- R6: When the final biased exponent is below 0, the result is sign plus 13 zero bits and `underflow` is 1; otherwise `underflow` is 0.
- R7: An operand whose bits 12:0 are all zero is a zero; the result is then signed zero with `underflow` 0.
- R8: With the register stage enabled, `out_valid`, `product` and `underflow` reflect the operands presented with `in_valid` one clock earlier.
- R9: With the register stage enabled, cycles with `in_valid` low leave `product` and `underflow` unchanged and drive `out_valid` low.
- R10: A synchronous active-low reset clears `out_valid`, `product` and `underflow` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on op_a/op_b are to be multiplied |
| op_a | input | 14 | First operand |
| op_b | input | 14 | Second operand |
| out_valid | output | 1 | product and underflow hold a new result |
| product | output | 14 | Truncated product |
| underflow | output | 1 | Result exponent fell below the smallest code and was flushed |

## Verification
A fault in the exponent path appears in bits 12:8 of the very next result: a missing bias, a missing increment after normalization, or a wrong sign test on the exponent. Operand pairs near the -1/0 exponent boundary separate these cases, because they make the flag and the flush flip. A wrong normalization select or a rounding increment corrupts the fraction field in the same cycle, so products of 1.5*1.5 and of values with small low-order fractions expose it at once. A register stage that loads while idle becomes visible one cycle after any idle cycle with changed operands.

// File: rtl/fpm_pkg.sv
// Shared format constants and field view for the 14-bit multiplier.
// Assumes a sign/exponent/fraction word with an implicit leading one.
package fpm_pkg;
    parameter int EXP_W  = 5;
    parameter int FRAC_W = 8;
    parameter int BIAS   = 15;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int ESUM_W = EXP_W + 3;

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  ex;
        logic [FRAC_W-1:0] fr;
    } fpw_t;
endpackage

// File: rtl/fpm_exp_add.sv
// Exponent stage: adds two biased exponents and removes one bias.
// The result is two's complement in ESUM_W bits, so a negative value
// is marked by its top bit. The range is assumed never to wrap.
module fpm_exp_add
    import fpm_pkg::*;
(
    input  logic [EXP_W-1:0]  ex_a,
    input  logic [EXP_W-1:0]  ex_b,
    output logic [ESUM_W-1:0] ex_sum
);
    localparam logic [ESUM_W-1:0] BIAS_W = ESUM_W'(BIAS);

    // Purpose: biased sum minus bias, widened to keep the sign
    always_comb begin
        ex_sum = {3'b000, ex_a} + {3'b000, ex_b} - BIAS_W;
    end
endmodule

// File: rtl/fpm_sig_mul.sv
// Significand stage: restores the hidden ones and forms the full
// unsigned product of two (FRAC_W+1)-bit significands in [1,4).
module fpm_sig_mul
    import fpm_pkg::*;
(
    input  logic [FRAC_W-1:0] fr_a,
    input  logic [FRAC_W-1:0] fr_b,
    output logic [PROD_W-1:0] sig_prod
);
    logic [SIG_W-1:0] sig_a;
    logic [SIG_W-1:0] sig_b;

    // Purpose: attach implicit leading ones
    always_comb begin
        sig_a = {1'b1, fr_a};
        sig_b = {1'b1, fr_b};
    end

    // Purpose: full-width significand product
    always_comb begin
        sig_prod = PROD_W'(sig_a) * PROD_W'(sig_b);
    end
endmodule

// File: rtl/fpm_norm_trunc.sv
// Normalize, truncate and handle exceptions. A product at or above two
// is shifted right one place with an exponent increment. The kept
// fraction is cut off with no rounding. A negative final exponent or a
// zero operand yields signed zero; only the negative case raises the flag.
// Exponents above the top code are assumed never to occur.
module fpm_norm_trunc
    import fpm_pkg::*;
(
    input  logic              sgn,
    input  logic              is_zero,
    input  logic [ESUM_W-1:0] ex_sum,
    input  logic [PROD_W-1:0] sig_prod,
    output logic [WORD_W-1:0] result,
    output logic              uflow
);
    logic              carry_hi;
    logic [ESUM_W-1:0] ex_fin;
    logic [FRAC_W-1:0] fr_fin;
    fpw_t              packed_res;

    // Purpose: select the normalization shift and adjust the exponent
    always_comb begin
        carry_hi = sig_prod[PROD_W-1];
        ex_fin   = ex_sum + ESUM_W'(carry_hi);
        if (carry_hi) begin
            fr_fin = sig_prod[PROD_W-2 -: FRAC_W];
        end else begin
            fr_fin = sig_prod[PROD_W-3 -: FRAC_W];
        end
    end

    // Purpose: underflow test, flush and field packing
    always_comb begin
        uflow          = !is_zero && ex_fin[ESUM_W-1];
        packed_res.sgn = sgn;
        if (is_zero || uflow) begin
            packed_res.ex = '0;
            packed_res.fr = '0;
        end else begin
            packed_res.ex = ex_fin[EXP_W-1:0];
            packed_res.fr = fr_fin;
        end
        result = packed_res;
    end
endmodule

// File: rtl/fpm_mul14.sv
// Top of the reduced-precision multiplier. It splits the operand fields,
// runs the exponent and significand stages side by side, then the
// normalize/truncate stage. OUT_REG=1 adds one output register with a
// synchronous active-low reset. OUT_REG=0 makes the path combinational.
module fpm_mul14
    import fpm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] product,
    output logic              underflow
);
    fpw_t              fa;
    fpw_t              fb;
    logic [ESUM_W-1:0] ex_sum;
    logic [PROD_W-1:0] sig_prod;
    logic [WORD_W-1:0] res_c;
    logic              uf_c;
    logic              zero_in;
    logic              sgn_c;

    // Purpose: field view, result sign and zero-operand detection
    always_comb begin
        fa      = op_a;
        fb      = op_b;
        sgn_c   = fa.sgn ^ fb.sgn;
        zero_in = ({fa.ex, fa.fr} == '0) || ({fb.ex, fb.fr} == '0);
    end

    fpm_exp_add u_exp (
        .ex_a   (fa.ex),
        .ex_b   (fb.ex),
        .ex_sum (ex_sum)
    );

    fpm_sig_mul u_sig (
        .fr_a     (fa.fr),
        .fr_b     (fb.fr),
        .sig_prod (sig_prod)
    );

    fpm_norm_trunc u_norm (
        .sgn      (sgn_c),
        .is_zero  (zero_in),
        .ex_sum   (ex_sum),
        .sig_prod (sig_prod),
        .result   (res_c),
        .uflow    (uf_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Purpose: output register, loaded only on valid operands
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    product   <= '0;
                    underflow <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        product   <= res_c;
                        underflow <= uf_c;
                    end
                end
            end

            a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(product) && $stable(underflow)));
            a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (product[WORD_W-1] == ($past(op_a[WORD_W-1]) ^ $past(op_b[WORD_W-1]))));
            a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (op_a[WORD_W-2:0] == '0)) |=> (product[WORD_W-2:0] == '0 && !underflow));
            a_r6_flush_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
                underflow |-> (product[WORD_W-2:0] == '0));
        end else begin : g_comb
            // Purpose: combinational pass-through variant
            always_comb begin
                out_valid = in_valid;
                product   = res_c;
                underflow = uf_c;
            end
        end
    endgenerate
endmodule

// File: tb/fpm_mul14_tb_top.sv
// Directed bench for fpm_mul14 (registered variant), with a truncating reference model.
module fpm_mul14_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] op_a = '0;
    logic [13:0] op_b = '0;
    logic        out_valid;
    logic [13:0] product;
    logic        underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fpm_mul14 #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product), .underflow(underflow)
    );

    // Reference: returns {underflow, product} from the requirement text
    function automatic logic [14:0] ref_mul(input logic [13:0] a, input logic [13:0] b);
        int ma, mb, p, e, fr;
        logic s;
        s = a[13] ^ b[13];
        if (a[12:0] == 0 || b[12:0] == 0) return {1'b0, s, 13'd0};
        ma = 256 + int'(a[7:0]);
        mb = 256 + int'(b[7:0]);
        p  = ma * mb;
        e  = int'(a[12:8]) + int'(b[12:8]) - 15;
        if (p >= 131072) begin
            fr = (p / 512) - 256;
            e  = e + 1;
        end else begin
            fr = (p / 256) - 256;
        end
        if (e < 0) return {1'b1, s, 13'd0};
        return {1'b0, s, e[4:0], fr[7:0]};
    endfunction

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Apply one operand pair for one cycle, then sample after the register
    task automatic apply(input logic [13:0] a, input logic [13:0] b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic mul_check(input string req, input logic [13:0] a, input logic [13:0] b,
                             input logic [14:0] exp_v);
        apply(a, b);
        check(req, {underflow, product}, exp_v);
        check({req, "_valid"}, {14'd0, out_valid}, 15'd1);
        check({req, "_model"}, {underflow, product}, ref_mul(a, b));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10", {out_valid, underflow, product}, 16'd0);
    endtask

    task automatic t_basic();
        mul_check("R1", 14'h0F00, 14'h0F00, 15'h0F00);          // 1.0*1.0
        mul_check("R3", 14'h1100, 14'h0E00, 15'h1000);          // 4*0.5=2
    endtask

    task automatic t_sign();
        mul_check("R2", 14'h2F00, 14'h0F00, 15'h2F00);          // -1*1
        mul_check("R2", 14'h2F00, 14'h3080, 15'h1080);          // -1*-3
    endtask

    task automatic t_norm();
        mul_check("R4", 14'h0F80, 14'h0F80, 15'h1020);          // 1.5*1.5=2.25
        mul_check("R4", 14'h07C0, 14'h07C0, 15'h0088);          // -1 lifted to code 0
    endtask

    task automatic t_trunc();
        mul_check("R5", 14'h0F01, 14'h0F01, 15'h0F02);          // tail 1/65536 dropped
        mul_check("R5", 14'h0FFF, 14'h0FFF, 15'h10FE);          // no round-up
    endtask

    task automatic t_code0();
        mul_check("R3", 14'h0740, 14'h0800, 15'h0040);          // exp 0 normal result
        mul_check("R3", 14'h0040, 14'h0F00, 15'h0040);          // exp-0 operand is 2^-15*1.25
    endtask

    task automatic t_underflow();
        mul_check("R6", 14'h0500, 14'h0500, 15'h4000);
        mul_check("R6", 14'h2700, 14'h07FF, 15'h6000);          // -1 stays below, signed flush
    endtask

    task automatic t_zero();
        mul_check("R7", 14'h0000, 14'h1E55, 15'h0000);
        mul_check("R7", 14'h2000, 14'h0F00, 15'h2000);          // -0 * 1
        mul_check("R7", 14'h0100, 14'h0000, 15'h0000);          // tiny * 0: no flag
    endtask

    task automatic t_hold();
        apply(14'h1080, 14'h0F00);                              // 3*1=3 -> 0x1080
        check("R8", {underflow, product}, 15'h1080);
        @(negedge clk);
        op_a = 14'h0500; op_b = 14'h0500;
        @(negedge clk);
        check("R9", {underflow, product}, 15'h1080);
        check("R9_valid", {14'd0, out_valid}, 15'd0);
    endtask

    task automatic t_sweep();
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            logic [13:0] a, b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a  = {lf[0], 5'(8 + (lf[7:4] % 15)), lf[15:8]};
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b  = {lf[1], 5'(lf[11:8] % 15), lf[7:0]};
            apply(a, b);
            check("R8_sweep", {underflow, product}, ref_mul(a, b));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_sign();
        t_norm();
        t_trunc();
        t_code0();
        t_underflow();
        t_zero();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule